// File: doc/BRIEF.md
# Bus Hold Request Arbiter

This block obtains and gives back ownership of a shared system bus on behalf of an internal DMA engine. It does this with a two-wire hold handshake: the block raises a hold request, and the processor or an external arbiter answers with a hold acknowledge. A second bus master can be chained below this block. Its hold request enters on `holdi_in`, is merged into the same upstream request, and the grant is handed back to it on `hldao_out`. A configuration bit decides which requester wins when both are waiting at the moment of arbitration.

The local engine can cancel its transfer at any time through `loc_abort`. This input stands for a stop command or a soft-reset register read. A cancellation never pulls back a hold request that is already on the bus. The request stays up until the acknowledge is seen, and then it is dropped on the next clock without any bus cycle. After any release, the block waits until the acknowledge has gone low before it arbitrates again, so a stale grant is never taken for a new one. `hlda_in` and `holdi_in` pass through a synchronizer of `SYNC_STAGES` flops (two by default). `loc_req`, `loc_abort` and `cfg_chain_first` are taken to be synchronous to `clk`. Every output comes straight from a register.

Top module: `bus_hold_arb`

## Requirements
- R1: While reset is asserted (`rst_n` low), `hold_out`, `hldao_out`, `dma_grant` and `dma_own` are all 0. Assertion of reset takes effect without waiting for a clock.
- R2: When the arbiter is idle and `loc_req`=1 with `loc_abort`=0, `hold_out` goes to 1 at the first rising clock edge that samples the request.
- R3: `hlda_in` and `holdi_in` reach the arbiter `SYNC_STAGES` (2) edges after they change. When a non-cancelled local request is pending, the edge that sees the synchronized acknowledge raises `dma_own` and gives `dma_grant` a pulse exactly one cycle wide. `dma_grant` is never 1 in any other case.
- R4: While the local engine owns the bus, clearing `loc_req` or setting `loc_abort` clears `hold_out` and `dma_own` at the next edge.
- R5: A local request cancelled (`loc_abort`=1 or `loc_req`=0) before its grant keeps `hold_out`=1 until the synchronized acknowledge is seen. `hold_out` then falls at that same edge. `dma_grant` and `dma_own` stay 0 throughout.
- R6: A chained request on `holdi_in` raises `hold_out`. Once the synchronized acknowledge is seen, `hldao_out`=1 while `dma_own` and `dma_grant` stay 0.
- R7: When `holdi_in` falls during a chained ownership, `hold_out` and `hldao_out` both go to 0.
- R8: When both requests are seen together at arbitration, `cfg_chain_first`=1 serves the chained request first and `cfg_chain_first`=0 serves the local request first.
- R9: After `hold_out` falls, no new request is raised until the synchronized acknowledge has been seen low.
- R10: If the acknowledge is withdrawn while either requester owns the bus, `hold_out` and that owner's indication (`dma_own` or `hldao_out`) fall.
- R11: A chained request withdrawn before its grant keeps `hold_out`=1 until the acknowledge arrives, then releases without setting `hldao_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus interface clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_chain_first | input | 1 | 1: chained request has priority; 0: local request has priority |
| loc_req | input | 1 | Local DMA engine wants the bus (level) |
| loc_abort | input | 1 | Cancel the local transfer (stop command or soft-reset read) |
| hlda_in | input | 1 | Hold acknowledge from the processor or the upstream arbiter |
| holdi_in | input | 1 | Hold request from the chained downstream master |
| hold_out | output | 1 | Hold request to the processor or the upstream arbiter |
| hldao_out | output | 1 | Hold acknowledge passed down to the chained master |
| dma_grant | output | 1 | One-cycle pulse: the local engine has just won the bus |
| dma_own | output | 1 | The local engine currently owns the bus |

## Verification
The assertions assume that the upstream acknowledge follows the handshake. It arrives only while a request is up or while it is being released, and it falls some time after `hold_out` falls. They also assume that `loc_abort` and `loc_req` are synchronous to `clk`. The stimulus keeps to these rules: every vector changes the inputs on a falling edge and then holds them for six cycles. That is longer than the synchronizer latency plus the release-and-rearbitrate path. The acknowledge is raised only after a request is visible, and dropped only after the owner has let go or to test a withdrawn grant. The directed tests count edges from each input change to check the exact cycle of the grant pulse and of the delayed hold release.

// File: rtl/bha_pkg.sv
package bha_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ_LOC,
    ST_OWN_LOC,
    ST_REQ_CHN,
    ST_OWN_CHN,
    ST_HOLD_ABORT,
    ST_REL_WAIT
  } arb_state_e;

  function automatic logic state_drives_hold(arb_state_e s);
    return (s == ST_REQ_LOC) || (s == ST_OWN_LOC) || (s == ST_REQ_CHN) ||
           (s == ST_OWN_CHN) || (s == ST_HOLD_ABORT);
  endfunction

endpackage

// File: rtl/bha_rst_sync.sv
module bha_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[LAST-1:0], 1'b1};
  end

  assign rst_sync_n = chain_q[LAST];
endmodule

// File: rtl/bha_sync.sv
module bha_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= async_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/bha_prio.sv
module bha_prio (
  input  logic loc_want,
  input  logic chn_want,
  input  logic chain_first,
  output logic pick_loc,
  output logic pick_chn
);
  always_comb begin
    pick_chn = chn_want && (chain_first || !loc_want);
    pick_loc = loc_want && !pick_chn;
  end
endmodule

// File: rtl/bha_fsm.sv
module bha_fsm
  import bha_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pick_loc,
  input  logic pick_chn,
  input  logic loc_req,
  input  logic loc_abort,
  input  logic hlda_s,
  input  logic holdi_s,
  output logic hold_q,
  output logic hldao_q,
  output logic grant_q,
  output logic own_q
);
  arb_state_e state_q, state_d;
  logic       grant_d;
  logic       loc_gone;

  assign loc_gone = loc_abort || !loc_req;

  always_comb begin
    state_d = state_q;
    grant_d = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (pick_chn)      state_d = ST_REQ_CHN;
        else if (pick_loc) state_d = ST_REQ_LOC;
      end
      ST_REQ_LOC: begin
        if (hlda_s) begin
          if (loc_gone) state_d = ST_REL_WAIT;
          else begin
            state_d = ST_OWN_LOC;
            grant_d = 1'b1;
          end
        end else if (loc_gone) begin
          state_d = ST_HOLD_ABORT;
        end
      end
      ST_OWN_LOC: begin
        if (!hlda_s || loc_gone) state_d = ST_REL_WAIT;
      end
      ST_REQ_CHN: begin
        if (hlda_s) state_d = holdi_s ? ST_OWN_CHN : ST_REL_WAIT;
        else if (!holdi_s) state_d = ST_HOLD_ABORT;
      end
      ST_OWN_CHN: begin
        if (!hlda_s || !holdi_s) state_d = ST_REL_WAIT;
      end
      ST_HOLD_ABORT: begin
        if (hlda_s) state_d = ST_REL_WAIT;
      end
      ST_REL_WAIT: begin
        if (!hlda_s) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      hold_q  <= 1'b0;
      hldao_q <= 1'b0;
      grant_q <= 1'b0;
      own_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      hold_q  <= state_drives_hold(state_d);
      hldao_q <= (state_d == ST_OWN_CHN);
      grant_q <= grant_d;
      own_q   <= (state_d == ST_OWN_LOC);
    end
  end
endmodule

// File: rtl/bus_hold_arb.sv
module bus_hold_arb #(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_chain_first,
  input  logic loc_req,
  input  logic loc_abort,
  input  logic hlda_in,
  input  logic holdi_in,
  output logic hold_out,
  output logic hldao_out,
  output logic dma_grant,
  output logic dma_own
);
  localparam int SYNC_W = 2;

  logic              rst_sync_n;
  logic [SYNC_W-1:0] sync_vec;
  logic              hlda_s, holdi_s;
  logic              loc_want, pick_loc, pick_chn;

  bha_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  bha_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_sync_n),
    .async_in({holdi_in, hlda_in}),
    .sync_out(sync_vec)
  );

  assign hlda_s   = sync_vec[0];
  assign holdi_s  = sync_vec[1];
  assign loc_want = loc_req && !loc_abort;

  bha_prio u_prio (
    .loc_want(loc_want), .chn_want(holdi_s), .chain_first(cfg_chain_first),
    .pick_loc(pick_loc), .pick_chn(pick_chn)
  );

  bha_fsm u_fsm (
    .clk(clk), .rst_n(rst_sync_n),
    .pick_loc(pick_loc), .pick_chn(pick_chn),
    .loc_req(loc_req), .loc_abort(loc_abort),
    .hlda_s(hlda_s), .holdi_s(holdi_s),
    .hold_q(hold_out), .hldao_q(hldao_out),
    .grant_q(dma_grant), .own_q(dma_own)
  );
endmodule

// File: rtl/bus_hold_arb_chk.sv
module bus_hold_arb_chk (
  input logic clk,
  input logic rst_n,
  input logic loc_abort,
  input logic hlda_s,
  input logic hold_out,
  input logic hldao_out,
  input logic dma_grant,
  input logic dma_own
);
  AST_GRANT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    dma_grant |=> !dma_grant); // R3
  AST_GRANT_WITH_OWN: assert property (@(posedge clk) disable iff (!rst_n)
    dma_grant |-> (dma_own && hold_out)); // R3
  AST_NO_GRANT_ON_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    dma_grant |-> !$past(loc_abort)); // R5
  AST_PENDING_HOLD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_out && !dma_own && !hldao_out && !hlda_s) |=> hold_out); // R5
  AST_OWNERS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(dma_own && hldao_out)); // R6
  AST_HLDAO_UNDER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    hldao_out |-> hold_out); // R6
  AST_NO_QUICK_REARB: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_out) |=> !hold_out); // R9
endmodule

bind bus_hold_arb bus_hold_arb_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .loc_abort(loc_abort), .hlda_s(hlda_s),
  .hold_out(hold_out), .hldao_out(hldao_out),
  .dma_grant(dma_grant), .dma_own(dma_own)
);

// File: tb/bus_hold_arb_tb.sv
`timescale 1ns/1ps
module bus_hold_arb_tb_top;
  localparam int SETTLE = 6;
  localparam int NVEC   = 26;
  // {cfg, loc_req, abort, hlda, holdi, exp_hold, exp_hldao, exp_own}
  localparam logic [7:0] VEC [NVEC] = '{
    8'b00000_000, // R1 idle
    8'b01000_100, // R2 local request
    8'b01010_101, // R3 local owns
    8'b00010_000, // R4 local release, ack still high
    8'b00000_000, // R9 back to idle
    8'b00001_100, // R6 chained request
    8'b00011_110, // R6 chained owns
    8'b00010_000, // R7 chained release
    8'b11011_000, // R9 both waiting, ack still high
    8'b11001_100, // R8 chained wins (cfg=1)
    8'b11011_110, // R8 chained owns
    8'b11010_000, // R7 chained release, local waits
    8'b11000_100, // R8 local next
    8'b11010_101, // R3 local owns
    8'b11011_101, // R6 holdi ignored while local owns
    8'b01001_100, // R10 ack withdrawn, rearbitrate: local wins (cfg=0)
    8'b01011_101, // R8 local owns
    8'b00000_000, // R4 release all
    8'b01000_100, // R2 local request
    8'b01100_100, // R5 abort keeps hold
    8'b01110_000, // R5 ack releases hold
    8'b00000_000, // R9 idle
    8'b00001_100, // R11 chained request
    8'b00000_100, // R11 withdrawn, hold kept
    8'b00010_000, // R11 ack releases without hldao
    8'b00000_000  // R11 idle
  };
  localparam int VREQ [NVEC] = '{1,2,3,4,9,6,6,7,9,8,8,7,8,3,6,10,8,4,2,5,5,9,11,11,11,11};

  logic clk = 1'b0;
  logic rst_n, cfg_chain_first, loc_req, loc_abort, hlda_in, holdi_in;
  logic hold_out, hldao_out, dma_grant, dma_own;
  int   checks = 0, failures = 0, grant_seen;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  bus_hold_arb dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_chain_first(cfg_chain_first),
    .loc_req(loc_req), .loc_abort(loc_abort), .hlda_in(hlda_in),
    .holdi_in(holdi_in), .hold_out(hold_out), .hldao_out(hldao_out),
    .dma_grant(dma_grant), .dma_own(dma_own)
  );

  task automatic chk(input string req, input string what, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [4:0] v);
    @(negedge clk);
    {cfg_chain_first, loc_req, loc_abort, hlda_in, holdi_in} = v;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0;
    {cfg_chain_first, loc_req, loc_abort, hlda_in, holdi_in} = '0;
    step(3);
    chk("R1", "outputs in reset", {hold_out, hldao_out, dma_grant, dma_own}, 4'b0000);
    rst_n = 1'b1;
    step(4);

    for (int r = 0; r < NVEC; r++) begin
      drive(VEC[r][7:3]);
      step(SETTLE);
      chk($sformatf("R%0d", VREQ[r]), $sformatf("vector %0d hold/hldao/own", r),
          {1'b0, hold_out, hldao_out, dma_own}, {1'b0, VEC[r][2:0]});
    end

    // R2: request visible after one edge
    drive(5'b01000);
    step(1);
    chk("R2", "hold one edge after request", {3'b0, hold_out}, 4'b0001);
    step(4);
    // R3: grant pulse timing
    drive(5'b01010);
    step(2);
    chk("R3", "before sync ack", {1'b0, hold_out, dma_grant, dma_own}, 4'b0100);
    step(1);
    chk("R3", "grant edge", {1'b0, hold_out, dma_grant, dma_own}, 4'b0111);
    step(1);
    chk("R3", "grant pulse ends", {1'b0, hold_out, dma_grant, dma_own}, 4'b0101);
    // R4: abort during ownership releases at next edge
    drive(5'b01110);
    step(1);
    chk("R4", "abort while owning", {2'b0, hold_out, dma_own}, 4'b0000);
    drive(5'b00000);
    step(SETTLE);

    // R5: abort with ack arriving together; hold kept two edges, falls on third
    drive(5'b01000);
    step(SETTLE);
    grant_seen = 0;
    drive(5'b01110);
    if (dma_grant) grant_seen++;
    step(1); if (dma_grant) grant_seen++;
    step(1); if (dma_grant) grant_seen++;
    chk("R5", "hold kept before sync ack", {3'b0, hold_out}, 4'b0001);
    step(1); if (dma_grant) grant_seen++;
    chk("R5", "hold drops at sync ack edge", {2'b0, hold_out, dma_own}, 4'b0000);
    for (int i = 0; i < 4; i++) begin step(1); if (dma_grant) grant_seen++; end
    chk("R5", "no grant after abort", grant_seen[3:0], 4'd0);
    drive(5'b00000);
    step(SETTLE);

    // R10: chained owner loses ack
    drive(5'b00001);
    step(SETTLE);
    drive(5'b00011);
    step(SETTLE);
    chk("R6", "chained owns", {2'b0, hold_out, hldao_out}, 4'b0011);
    drive(5'b00001);
    step(3);
    chk("R10", "chained ack withdrawn", {2'b0, hold_out, hldao_out}, 4'b0000);
    drive(5'b00000);
    step(SETTLE);

    // R1: asynchronous reset mid-ownership
    drive(5'b01000);
    step(SETTLE);
    drive(5'b01010);
    step(SETTLE);
    #1 rst_n = 1'b0;
    #0.5;
    chk("R1", "async reset clears outputs", {hold_out, hldao_out, dma_grant, dma_own}, 4'b0000);

    done = 1'b1;
    finish_run();
  end
endmodule